// File: doc/BRIEF.md
# Run-Time Energy Event Counter Bank

This block sits beside a processor's control path and tallies the activity that software needs in order to estimate energy use at run time. It takes raw control signals from the divider, the multiplier, the instruction cache, the register file and the data cache, and turns them into single-cycle event pulses. Most pulses are the AND of a few conditions. One pulse marks a change in a signal and needs a register that holds the previous value. Each event drives its own fixed-increment counter. A tenth counter advances on every clock and measures elapsed time.

Software reads the counters through a small memory-mapped read port in an uncached region. The read port decodes the word address and selects one counter onto a registered data output. A read also clears the counter it returns. Two reads of the same counter therefore give the tally for the interval between them, and the counters seldom reach their 32-bit limit. A counter that does overflow wraps around to zero.

Top module: `evtcnt_bank`

## Requirements
- R1: After reset every counter holds zero and `bus_rdata` is zero.
- R2: The counter at byte offset 0x00 advances by one on every clock edge.
- R3: The counters at 0x04, 0x08 and 0x0C each advance by one for every cycle in which `div_busy`, `mul_busy` or `ic_access` respectively is high.
- R4: The counter at 0x10 advances by one for every cycle in which `rf_wr_en` is high.
- R5: The counter at 0x14 advances by one in each cycle where `issue` is high and the pair {`rs2`,`rs1`} differs from the pair presented at the previous `issue` cycle. After reset the remembered pair is all zeros. Cycles without `issue` neither count nor update the remembered pair.
- R6: The data-cache counters advance as follows. Offset 0x18 counts misses (`dc_req` high, `dc_hit` low). Offset 0x1C counts `dc_wb` cycles. Offset 0x20 counts read hits (`dc_req`, `dc_hit` high and `dc_we` low). Offset 0x24 counts write hits (`dc_req`, `dc_hit` and `dc_we` all high).
- R7: A read is an access with `bus_sel` high and `bus_we` low at a word-aligned offset i*4 with i below 10. The cycle after a read, `bus_rdata` shows the value counter i held before that read's clock edge. In every other cycle `bus_rdata` is zero.
- R8: A read leaves its counter at zero, or at one if that counter's event fires in the read cycle.
- R9: An access with `bus_we` high clears nothing, and counting carries on through it; `bus_rdata` is zero after it.
- R10: A read at an offset with i of 10 or more, or at an offset that is not word-aligned, returns zero and clears no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_busy | input | 1 | Divider in use |
| mul_busy | input | 1 | Multiplier in use |
| ic_access | input | 1 | Instruction cache accessed |
| rf_wr_en | input | 1 | Register file write |
| issue | input | 1 | Instruction issued with valid read selects |
| rs1 | input | 5 | First register read select |
| rs2 | input | 5 | Second register read select |
| dc_req | input | 1 | Data cache access |
| dc_we | input | 1 | Data cache access is a store |
| dc_hit | input | 1 | Data cache lookup hit |
| dc_wb | input | 1 | Data cache write-back of a dirty line |
| bus_sel | input | 1 | Access to the counter region |
| bus_we | input | 1 | Access is a write (ignored) |
| bus_addr | input | 6 | Byte offset in the counter region |
| bus_rdata | output | 32 | Registered read data |

## Verification
The case that needs care is a clear-on-read landing in the same cycle as that counter's own event. In that cycle the read returns the old tally and the counter restarts at one rather than zero. The bench provokes this by holding `div_busy` high across the edge of a divider-counter read. It expects the earlier count back, then a count of exactly one from the next read. The cycle counter is judged the same way by two reads of offset 0x00 on consecutive cycles; the second read must return one.

// File: rtl/evtcnt_pkg.sv
package evtcnt_pkg;
    localparam int CNT_W  = 32;
    localparam int N_CNT  = 10;
    localparam int RSEL_W = 5;

    localparam int IX_CYC   = 0;
    localparam int IX_DIV   = 1;
    localparam int IX_MUL   = 2;
    localparam int IX_IC    = 3;
    localparam int IX_RFWR  = 4;
    localparam int IX_RFSEL = 5;
    localparam int IX_DMISS = 6;
    localparam int IX_DWB   = 7;
    localparam int IX_DRHIT = 8;
    localparam int IX_DWHIT = 9;

    typedef struct packed {
        logic [2*RSEL_W-1:0] prev_sel;
    } dec_state_t;
endpackage

// File: rtl/evt_decode.sv
module evt_decode
    import evtcnt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              div_busy,
    input  logic              mul_busy,
    input  logic              ic_access,
    input  logic              rf_wr_en,
    input  logic              issue,
    input  logic [RSEL_W-1:0] rs1,
    input  logic [RSEL_W-1:0] rs2,
    input  logic              dc_req,
    input  logic              dc_we,
    input  logic              dc_hit,
    input  logic              dc_wb,
    output logic [N_CNT-1:0]  evt
);
    dec_state_t st_d, st_q;
    logic [2*RSEL_W-1:0] cur_sel;

    always_comb begin
        cur_sel = {rs2, rs1};
        st_d    = st_q;
        if (issue) st_d.prev_sel = cur_sel;

        evt            = '0;
        evt[IX_CYC]    = 1'b1;
        evt[IX_DIV]    = div_busy;
        evt[IX_MUL]    = mul_busy;
        evt[IX_IC]     = ic_access;
        evt[IX_RFWR]   = rf_wr_en;
        evt[IX_RFSEL]  = issue && (cur_sel != st_q.prev_sel);
        evt[IX_DMISS]  = dc_req && !dc_hit;
        evt[IX_DWB]    = dc_wb;
        evt[IX_DRHIT]  = dc_req && dc_hit && !dc_we;
        evt[IX_DWHIT]  = dc_req && dc_hit && dc_we;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5: a select-change event is only ever raised on an issue cycle
    p_selchg_issue_r5: assert property (@(posedge clk) disable iff (!rst_n)
        evt[IX_RFSEL] |-> issue);
    // R6: a data cache access is at most one of miss, read hit, write hit
    p_dc_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({evt[IX_DMISS], evt[IX_DRHIT], evt[IX_DWHIT]}));
endmodule

// File: rtl/evt_counter.sv
module evt_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = (clr ? '0 : cnt_q) + W'(inc);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

    // R8: a read with no concurrent event leaves zero
    p_clr_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !inc) |=> (cnt_q == '0));
    // R8: a read with a concurrent event leaves one
    p_clr_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && inc) |=> (cnt_q == W'(1)));
    // R9: with neither read nor event the count holds
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !inc) |=> $stable(cnt_q));
endmodule

// File: rtl/evt_rdmux.sv
module evt_rdmux
    import evtcnt_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_sel,
    input  logic                        bus_we,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [N_CNT-1:0][CNT_W-1:0] cnt,
    output logic [N_CNT-1:0]            clr,
    output logic [CNT_W-1:0]            rdata
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    logic             rd_ok;
    logic [CNT_W-1:0] rdata_d, rdata_q;

    always_comb begin
        idx     = bus_addr[ADDR_W-1:2];
        rd_ok   = bus_sel && !bus_we && (bus_addr[1:0] == 2'b00)
                  && (int'(idx) < N_CNT);
        rdata_d = '0;
        clr     = '0;
        for (int i = 0; i < N_CNT; i++) begin
            if (rd_ok && (int'(idx) == i)) begin
                rdata_d = cnt[i];
                clr[i]  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;

    // R7: no mapped read means zero data next cycle
    p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_ok |=> (rdata_q == '0));
    // R10: at most one counter is cleared per cycle, and none without a read
    p_one_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr) && (rd_ok || (clr == '0)));
endmodule

// File: rtl/evtcnt_bank.sv
module evtcnt_bank
    import evtcnt_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              div_busy,
    input  logic              mul_busy,
    input  logic              ic_access,
    input  logic              rf_wr_en,
    input  logic              issue,
    input  logic [RSEL_W-1:0] rs1,
    input  logic [RSEL_W-1:0] rs2,
    input  logic              dc_req,
    input  logic              dc_we,
    input  logic              dc_hit,
    input  logic              dc_wb,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic [CNT_W-1:0]  bus_rdata
);
    logic [N_CNT-1:0]            evt;
    logic [N_CNT-1:0]            clr;
    logic [N_CNT-1:0][CNT_W-1:0] cnt;

    evt_decode u_dec (
        .clk, .rst_n, .div_busy, .mul_busy, .ic_access, .rf_wr_en,
        .issue, .rs1, .rs2, .dc_req, .dc_we, .dc_hit, .dc_wb, .evt
    );

    for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
        evt_counter #(.W(CNT_W)) u_cnt (
            .clk, .rst_n, .inc(evt[g]), .clr(clr[g]), .cnt(cnt[g])
        );
    end

    evt_rdmux #(.ADDR_W(ADDR_W)) u_mux (
        .clk, .rst_n, .bus_sel, .bus_we, .bus_addr, .cnt, .clr,
        .rdata(bus_rdata)
    );

    // R2: the elapsed-time counter is never zero once a clock edge has passed
    p_cycle_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cnt[IX_CYC] != '0));
    // R9: a write access leaves every counter uncleared
    p_write_noclr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |-> (clr == '0));
endmodule

// File: tb/tb_evtcnt_bank.sv
module tb_evtcnt_bank;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic div_busy = 0, mul_busy = 0, ic_access = 0, rf_wr_en = 0, issue = 0;
    logic [4:0] rs1 = '0, rs2 = '0;
    logic dc_req = 0, dc_we = 0, dc_hit = 0, dc_wb = 0;
    logic bus_sel = 0, bus_we = 0;
    logic [5:0] bus_addr = '0;
    logic [31:0] bus_rdata;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    evtcnt_bank dut (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // called at a negedge, returns at a negedge
    task automatic rd(input logic [5:0] a, output logic [31:0] v);
        bus_sel = 1; bus_we = 0; bus_addr = a;
        @(negedge clk);
        bus_sel = 0;
        v = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 rdata", bus_rdata, 0);
        rd(6'h00, v); check("R1 cycle", v, 0);
        rd(6'h04, v); check("R1 div", v, 0);
        rd(6'h24, v); check("R1 write hit", v, 0);
    endtask

    task automatic t_regfile();
        logic [31:0] v;
        // pairs: (0,0) same as reset, (1,2) change, (1,2) same,
        // non-issue (3,3), (1,2) same, (3,3) change
        issue = 1; rs1 = 0; rs2 = 0; @(negedge clk);
        rs1 = 1; rs2 = 2; @(negedge clk);
        @(negedge clk);
        issue = 0; rs1 = 3; rs2 = 3; @(negedge clk);
        issue = 1; rs1 = 1; rs2 = 2; @(negedge clk);
        rs1 = 3; rs2 = 3; @(negedge clk);
        issue = 0;
        rd(6'h14, v); check("R5 select changes", v, 2);
        rf_wr_en = 1; repeat (3) @(negedge clk); rf_wr_en = 0;
        @(negedge clk); rf_wr_en = 1; @(negedge clk); rf_wr_en = 0;
        rd(6'h10, v); check("R4 reg writes", v, 4);
    endtask

    task automatic t_units();
        logic [31:0] v;
        div_busy = 1; repeat (5) @(negedge clk); div_busy = 0;
        rd(6'h04, v); check("R3 div", v, 5);
        mul_busy = 1; repeat (7) @(negedge clk); mul_busy = 0;
        rd(6'h08, v); check("R3 mul", v, 7);
        ic_access = 1; @(negedge clk); ic_access = 0; @(negedge clk);
        ic_access = 1; @(negedge clk); ic_access = 0;
        rd(6'h0C, v); check("R3 icache", v, 2);
    endtask

    task automatic t_dcache();
        logic [31:0] v;
        dc_req = 1; dc_hit = 0; dc_we = 0; @(negedge clk);
        dc_we = 1; @(negedge clk);
        dc_hit = 1; dc_we = 0; repeat (3) @(negedge clk);
        dc_we = 1; repeat (4) @(negedge clk);
        dc_req = 0; dc_we = 0; repeat (2) @(negedge clk);
        dc_hit = 0; dc_wb = 1; @(negedge clk); dc_wb = 0;
        rd(6'h18, v); check("R6 miss", v, 2);
        rd(6'h1C, v); check("R6 write-back", v, 1);
        rd(6'h20, v); check("R6 read hit", v, 3);
        rd(6'h24, v); check("R6 write hit", v, 4);
    endtask

    task automatic t_cycle();
        logic [31:0] v;
        rd(6'h00, v);
        check("R7 idle rdata", bus_rdata, v);
        rd(6'h00, v); check("R8 cycle back-to-back", v, 1);
        @(negedge clk);
        check("R7 rdata zero after idle", bus_rdata, 0);
        repeat (8) @(negedge clk);
        rd(6'h00, v); check("R2 cycle interval", v, 10);
    endtask

    task automatic t_same_cycle();
        logic [31:0] v;
        rd(6'h04, v);
        div_busy = 1; repeat (2) @(negedge clk);
        rd(6'h04, v); check("R8 read during event", v, 2);
        div_busy = 0;
        rd(6'h04, v); check("R8 restart at one", v, 1);
    endtask

    task automatic t_write();
        logic [31:0] v;
        div_busy = 1; repeat (4) @(negedge clk); div_busy = 0;
        bus_sel = 1; bus_we = 1; bus_addr = 6'h04; @(negedge clk);
        bus_sel = 0; bus_we = 0;
        check("R9 write rdata", bus_rdata, 0);
        rd(6'h04, v); check("R9 write ignored", v, 4);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        mul_busy = 1; repeat (3) @(negedge clk); mul_busy = 0;
        rd(6'h28, v); check("R10 index ten", v, 0);
        rd(6'h3C, v); check("R10 top offset", v, 0);
        rd(6'h09, v); check("R10 misaligned", v, 0);
        rd(6'h08, v); check("R10 no clear", v, 3);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_regfile();
        t_units();
        t_dcache();
        t_cycle();
        t_same_cycle();
        t_write();
        t_unmapped();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule